// File: doc/BRIEF.md
# SPI ADC Channel-Scan Controller

This block is an SPI master that drives an external eight-channel, 12-bit successive-approximation converter that is kept in manual channel-select mode. A single start pulse runs one of two jobs. A scan writes the channel-select register once per frame, for channels 0 to 7 in turn. It then sends two drain frames, because a result leaves the converter two frames after the frame that chose its channel. Each result is presented as a 12-bit code with a 3-bit channel tag.

The second job is a link self-test. It switches the converter into its fixed-output mode, reads the pattern back and restores normal output. The test passes only when the 12-bit word is 0xA5A. This confirms the wiring and clock phase without depending on the analog inputs.

The serial clock is a symmetric division of the system clock. Chip select has a programmable setup delay before the first rising edge and a guaranteed idle gap between frames.

Top module: `adc_scan_ctrl`

## Requirements
- R1: Every frame holds `cs_n` low across exactly 24 rising `sclk` edges. `sclk` is low whenever `cs_n` is high. `mosi` shifts the 24-bit word out most significant bit first, changing only while `sclk` is low.
- R2: A scan sends 10 frames. Frame i (i < 8) is opcode 0x08, address 0x11, data byte i (channel index in bits [2:0]). Frames 8 and 9 write channel 0 to the same register.
- R3: Each `sclk` high phase and each low phase between rising edges lasts exactly HALF_DIV system-clock cycles.
- R4: `cs_n` falls at least CS_SETUP system cycles before the first rising `sclk` edge of a frame. Between frames, `cs_n` stays high for at least 2*HALF_DIV system cycles (one `sclk` period).
- R5: A scan gives exactly 8 `sample_valid` pulses, tagged 0 to 7 in order. The sample tagged c carries the first 12 bits received (MSB first) in the frame sent two frames after the one that selected c. Codes pass through unchanged, full scale 0xFFF included. The first two frames give no sample.
- R6: A self-test sends three frames: 0x08/0x02/0x80 (fixed pattern on), 0x10/0x02/0x00 (register read), 0x08/0x02/0x00 (fixed pattern off). It produces no `sample_valid`.
- R7: After a self-test, `test_pass` is 1 and `test_fail` is 0 when the first 12 bits of the third frame equal 0xA5A. Any other value gives the opposite. Both flags clear when the next self-test starts and otherwise hold.
- R8: A `start` seen while idle raises `busy` on the next clock edge. `done` is a one-cycle pulse issued in the cycle `busy` falls. `start` while busy is ignored.
- R9: Under reset `cs_n`=1, `sclk`=0, `mosi`=0, and `busy`, `done`, `sample_valid`, `test_pass` and `test_fail` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a job when idle |
| mode_test | input | 1 | Sampled with start: 1 self-test, 0 scan |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| sample_valid | output | 1 | Sample strobe |
| sample_ch | output | 3 | Channel tag of the sample |
| sample_data | output | 12 | Conversion code |
| test_pass | output | 1 | Self-test received the fixed pattern |
| test_fail | output | 1 | Self-test received something else |
| cs_n | output | 1 | SPI chip select, active low |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | SPI data to converter |
| miso | input | 1 | SPI data from converter |

## Verification
A frame index that slips by one shows up at the ports in two ways: a channel byte on `mosi` that does not match the frame number, and a sample whose code belongs to a neighbouring channel. Both appear within the first frames of a scan. If the pipeline offset is wrong, the tags and codes disagree from the first `sample_valid` onward. A divider or phase-counter fault shows up within a single `sclk` period as an asymmetric phase or a wrong edge count per frame. A bad self-test comparison flips `test_pass` in the cycle `done` rises.

// File: rtl/adc_scan_pkg.sv
// Shared constants and types for the ADC channel-scan controller.
// Assumes a converter with 8-bit opcode, address and data fields.
package adc_scan_pkg;
    localparam logic [7:0]  OP_WR        = 8'h08;
    localparam logic [7:0]  OP_RD        = 8'h10;
    localparam logic [7:0]  REG_CHSEL    = 8'h11;
    localparam logic [7:0]  REG_DCFG     = 8'h02;
    localparam logic [7:0]  DCFG_FIXPAT  = 8'h80;
    localparam logic [7:0]  DCFG_NORMAL  = 8'h00;
    localparam logic [11:0] FIX_CODE     = 12'hA5A;
    localparam int          BYTE_W       = 8;
    localparam int          FRAME_BYTES  = 3;
    localparam int          TEST_FRAMES  = 3;

    typedef enum logic [2:0] {
        E_IDLE, E_SETUP, E_LOW, E_HIGH, E_GAP
    } eng_state_t;
endpackage

// File: rtl/scan_frame_engine.sv
// Runs one SPI mode-0 frame per start pulse: chip select low, a setup
// delay, FRAME_W symmetric clock periods (MSB first out, capture on the
// rising edge), then a chip-select-high gap of one clock period before
// pulsing done with the received word.
// Assumes HALF_DIV >= 1, CS_SETUP >= 1 and start only while idle.
module scan_frame_engine
    import adc_scan_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CS_SETUP = 3,
    parameter int FRAME_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx,
    output logic               done,
    output logic [FRAME_W-1:0] rx,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso
);
    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int CNT_MAX = (GAP_CYC > CS_SETUP) ? GAP_CYC : CS_SETUP;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int BW      = $clog2(FRAME_W);

    eng_state_t         st;
    logic [CW-1:0]      cnt;
    logic [BW-1:0]      bitn;
    logic [FRAME_W-1:0] sh;

    // Output bit is the top of the shift register while selected.
    assign mosi = ~cs_n & sh[FRAME_W-1];

    // Frame sequencing: setup, low/high phases per bit, trailing gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= E_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            rx   <= '0;
            cs_n <= 1'b1;
            sclk <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                E_IDLE: if (start) begin
                    sh   <= tx;
                    cs_n <= 1'b0;
                    cnt  <= '0;
                    bitn <= '0;
                    st   <= E_SETUP;
                end
                E_SETUP: if (cnt == CW'(CS_SETUP - 1)) begin
                    cnt <= '0;
                    st  <= E_LOW;
                end else cnt <= cnt + 1'b1;
                E_LOW: if (cnt == CW'(HALF_DIV - 1)) begin
                    cnt  <= '0;
                    sclk <= 1'b1;
                    rx   <= {rx[FRAME_W-2:0], miso};
                    st   <= E_HIGH;
                end else cnt <= cnt + 1'b1;
                E_HIGH: if (cnt == CW'(HALF_DIV - 1)) begin
                    cnt  <= '0;
                    sclk <= 1'b0;
                    if (bitn == BW'(FRAME_W - 1)) begin
                        cs_n <= 1'b1;
                        st   <= E_GAP;
                    end else begin
                        bitn <= bitn + 1'b1;
                        sh   <= {sh[FRAME_W-2:0], 1'b0};
                        st   <= E_LOW;
                    end
                end else cnt <= cnt + 1'b1;
                E_GAP: if (cnt == CW'(GAP_CYC - 1)) begin
                    cnt  <= '0;
                    done <= 1'b1;
                    st   <= E_IDLE;
                end else cnt <= cnt + 1'b1;
                default: st <= E_IDLE;
            endcase
        end
    end

    // Checker state: length of the current high phase and of the CS-high run.
    logic [CW:0] hi_len;
    logic [CW:0] gap_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len  <= '0;
            gap_len <= (CW+1)'(GAP_CYC);
        end else begin
            hi_len  <= sclk ? hi_len + 1'b1 : '0;
            gap_len <= !cs_n ? '0 :
                       (gap_len == (CW+1)'(GAP_CYC)) ? gap_len : gap_len + 1'b1;
        end
    end

    a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    a_r3_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hi_len == (CW+1)'(HALF_DIV));
    a_r4_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> gap_len >= (CW+1)'(GAP_CYC));
endmodule

// File: rtl/scan_sequencer.sv
// Chooses the frame contents for a scan or a self-test, counts frames,
// tags each received code with the channel chosen PIPE frames earlier,
// and judges the fixed-pattern self-test.
// Assumes the frame engine accepts fr_start only between frames.
module scan_sequencer
    import adc_scan_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int PIPE    = 2,
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 24,
    parameter int CH_W    = $clog2(N_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode_test,
    output logic               fr_start,
    output logic [FRAME_W-1:0] fr_tx,
    input  logic               fr_done,
    input  logic [FRAME_W-1:0] fr_rx,
    output logic               busy,
    output logic               done,
    output logic               sample_valid,
    output logic [CH_W-1:0]    sample_ch,
    output logic [DATA_W-1:0]  sample_data,
    output logic               test_pass,
    output logic               test_fail
);
    localparam int N_SCAN = N_CH + PIPE;
    localparam int FI_W   = $clog2(N_SCAN + 1);

    logic [FI_W-1:0]   fi;
    logic              mode_q;
    logic              last;
    logic [CH_W-1:0]   sel_ch;
    logic [DATA_W-1:0] rx_code;

    assign last    = mode_q ? (fi == FI_W'(TEST_FRAMES - 1)) : (fi == FI_W'(N_SCAN - 1));
    assign sel_ch  = (fi < FI_W'(N_CH)) ? fi[CH_W-1:0] : '0;
    assign rx_code = fr_rx[FRAME_W-1 -: DATA_W];

    // Frame word for the current index and job.
    always_comb begin
        if (mode_q) begin
            case (fi)
                FI_W'(0): fr_tx = {OP_WR, REG_DCFG, DCFG_FIXPAT};
                FI_W'(1): fr_tx = {OP_RD, REG_DCFG, 8'h00};
                default:  fr_tx = {OP_WR, REG_DCFG, DCFG_NORMAL};
            endcase
        end else begin
            fr_tx = {OP_WR, REG_CHSEL, {(BYTE_W - CH_W){1'b0}}, sel_ch};
        end
    end

    // Job control, sample tagging and self-test verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fi           <= '0;
            mode_q       <= 1'b0;
            busy         <= 1'b0;
            done         <= 1'b0;
            fr_start     <= 1'b0;
            sample_valid <= 1'b0;
            sample_ch    <= '0;
            sample_data  <= '0;
            test_pass    <= 1'b0;
            test_fail    <= 1'b0;
        end else begin
            done         <= 1'b0;
            sample_valid <= 1'b0;
            fr_start     <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    mode_q   <= mode_test;
                    fi       <= '0;
                    fr_start <= 1'b1;
                    if (mode_test) begin
                        test_pass <= 1'b0;
                        test_fail <= 1'b0;
                    end
                end
            end else if (fr_done) begin
                if (!mode_q && fi >= FI_W'(PIPE)) begin
                    sample_valid <= 1'b1;
                    sample_ch    <= CH_W'(fi - FI_W'(PIPE));
                    sample_data  <= rx_code;
                end
                if (mode_q && last) begin
                    test_pass <= (rx_code == DATA_W'(FIX_CODE));
                    test_fail <= (rx_code != DATA_W'(FIX_CODE));
                end
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    fi       <= fi + 1'b1;
                    fr_start <= 1'b1;
                end
            end
        end
    end

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_pass && test_fail));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/adc_scan_ctrl.sv
// Top of the ADC channel-scan controller: a sequencer that plans frames
// and a frame engine that drives the SPI pins.
// Assumes a converter with a two-frame result delay in manual select mode.
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int N_CH     = 8,
    parameter int DATA_W   = 12,
    parameter int PIPE     = 2,
    parameter int HALF_DIV = 2,
    parameter int CS_SETUP = 3,
    parameter int CH_W     = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_test,
    output logic              busy,
    output logic              done,
    output logic              sample_valid,
    output logic [CH_W-1:0]   sample_ch,
    output logic [DATA_W-1:0] sample_data,
    output logic              test_pass,
    output logic              test_fail,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int FRAME_W = FRAME_BYTES * BYTE_W;

    logic               fr_start;
    logic               fr_done;
    logic [FRAME_W-1:0] fr_tx;
    logic [FRAME_W-1:0] fr_rx;

    scan_sequencer #(
        .N_CH(N_CH), .PIPE(PIPE), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .CH_W(CH_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_test(mode_test),
        .fr_start(fr_start), .fr_tx(fr_tx), .fr_done(fr_done), .fr_rx(fr_rx),
        .busy(busy), .done(done), .sample_valid(sample_valid),
        .sample_ch(sample_ch), .sample_data(sample_data),
        .test_pass(test_pass), .test_fail(test_fail)
    );

    scan_frame_engine #(
        .HALF_DIV(HALF_DIV), .CS_SETUP(CS_SETUP), .FRAME_W(FRAME_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(fr_start), .tx(fr_tx),
        .done(fr_done), .rx(fr_rx), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .miso(miso)
    );
endmodule

// File: tb/adc_scan_ctrl_tb.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb;
    localparam int H = 2;
    localparam int S = 3;
    // Stimulus: converter codes ch7..ch0; expected sample for tag c is field c.
    localparam logic [95:0] VEC [3] = '{
        {12'hFFF, 12'h123, 12'h7FF, 12'h001, 12'h800, 12'h3C3, 12'h456, 12'h000},
        {12'h0AA, 12'hF0F, 12'h555, 12'h9AB, 12'hE00, 12'h00F, 12'hC81, 12'hFFF},
        {12'h777, 12'h666, 12'h555, 12'h444, 12'h333, 12'h222, 12'h111, 12'hABC}
    };

    logic clk = 0, rst_n = 0, start = 0, mode_test = 0, miso = 0;
    logic busy, done, sample_valid, test_pass, test_fail, cs_n, sclk, mosi;
    logic [2:0]  sample_ch;
    logic [11:0] sample_data;

    always #2 clk = ~clk;

    adc_scan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_test(mode_test),
        .busy(busy), .done(done), .sample_valid(sample_valid),
        .sample_ch(sample_ch), .sample_data(sample_data),
        .test_pass(test_pass), .test_fail(test_fail),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0, n_fail = 0;
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Converter model and pin monitor, sampled on the falling system edge.
    logic [95:0] cur_vec = '0;
    bit          model_no_fix = 0;
    logic [23:0] m_in, m_out;
    logic [2:0]  m_ch = 0;
    logic        m_fix = 0;
    logic [11:0] m_q1 = 0, m_q2 = 0;
    logic [23:0] frames [64];
    int nfr = 0, nsamp = 0, done_cnt = 0, busy_at_done = 0;
    logic [2:0]  s_ch [16];
    logic [11:0] s_dat [16];
    logic cs_p = 1, sc_p = 0;
    int hi_run = 100, setup_run = 0, lo_run = 0, hi_len = 0, rises = 0;
    bit first_rise = 0;
    int gap_err = 0, setup_err = 0, duty_err = 0, bits_err = 0, idle_err = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_valid) begin
                if (nsamp < 16) begin s_ch[nsamp] = sample_ch; s_dat[nsamp] = sample_data; end
                nsamp++;
            end
            if (done) begin done_cnt++; if (busy) busy_at_done++; end
            if (cs_n && sclk) idle_err++;
            if (!cs_n && cs_p) begin
                if (hi_run < 2*H) gap_err++;
                setup_run = 0; first_rise = 1; rises = 0;
                m_out = {(m_fix && !model_no_fix) ? 12'hA5A : m_q2, 12'h000};
                m_in = '0;
            end
            if (!cs_n && sclk && !sc_p) begin
                rises++;
                m_in = {m_in[22:0], mosi};
                if (first_rise) begin
                    if (setup_run < S) setup_err++;
                    first_rise = 0;
                end else if (lo_run != H) duty_err++;
            end
            if (!sclk && sc_p) begin
                if (hi_len != H) duty_err++;
                m_out = {m_out[22:0], 1'b0};
            end
            if (cs_n && !cs_p) begin
                if (rises != 24) bits_err++;
                if (nfr < 64) frames[nfr] = m_in;
                nfr++;
                if (m_in[23:16] == 8'h08 && m_in[15:8] == 8'h11) m_ch = m_in[2:0];
                if (m_in[23:16] == 8'h08 && m_in[15:8] == 8'h02) m_fix = m_in[7];
                m_q2 = m_q1;
                m_q1 = cur_vec[m_ch*12 +: 12];
            end
            miso = cs_n ? 1'b0 : m_out[23];
            hi_run = cs_n ? hi_run + 1 : 0;
            if (!cs_n && first_rise) setup_run++;
            lo_run = sclk ? 0 : lo_run + 1;
            hi_len = sclk ? hi_len + 1 : 0;
            cs_p = cs_n; sc_p = sclk;
        end
    end

    task automatic wait_done();
        int d0 = done_cnt;
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic kick(input logic test);
        @(negedge clk); start = 1; mode_test = test;
        @(negedge clk); start = 0;
        check(busy == 1'b1, "R8 busy after start", busy, 1);
    endtask

    task automatic check_scan(input logic [95:0] v);
        check(nfr == 10, "R2 scan frame count", nfr, 10);
        for (int i = 0; i < 10 && i < nfr; i++)
            check(frames[i] == {8'h08, 8'h11, 8'((i < 8) ? i : 0)}, "R2 scan frame word",
                  frames[i], {8'h08, 8'h11, 8'((i < 8) ? i : 0)});
        check(nsamp == 8, "R5 sample count", nsamp, 8);
        for (int i = 0; i < 8 && i < nsamp; i++) begin
            check(s_ch[i] == 3'(i), "R5 sample tag", s_ch[i], i);
            check(s_dat[i] == v[i*12 +: 12], "R5 sample code", s_dat[i], v[i*12 +: 12]);
        end
    endtask

    bit finished = 0;
    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        check(cs_n == 1 && sclk == 0 && mosi == 0, "R9 pins in reset", {cs_n, sclk, mosi}, 3'b100);
        check(!busy && !done && !sample_valid && !test_pass && !test_fail,
              "R9 status in reset", {busy, done, sample_valid, test_pass, test_fail}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // Vector table: one scan per entry
        for (int v = 0; v < 3; v++) begin
            cur_vec = VEC[v]; nfr = 0; nsamp = 0;
            kick(1'b0);
            wait_done();
            check(busy_at_done == 0, "R8 busy low with done", busy_at_done, 0);
            check_scan(VEC[v]);
        end

        // R8: start while busy is ignored
        cur_vec = VEC[0]; nfr = 0; nsamp = 0;
        kick(1'b0);
        repeat (300) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
        wait_done();
        repeat (50) @(negedge clk);
        check(nfr == 10 && nsamp == 8, "R8 start while busy ignored", nfr, 10);
        check(!busy, "R8 idle after done", busy, 0);

        // R6/R7 self-test with working fixed pattern
        nfr = 0; nsamp = 0;
        kick(1'b1);
        wait_done();
        check(nfr == 3, "R6 self-test frame count", nfr, 3);
        check(frames[0] == 24'h080280, "R6 frame 0", frames[0], 24'h080280);
        check(frames[1] == 24'h100200, "R6 frame 1", frames[1], 24'h100200);
        check(frames[2] == 24'h080200, "R6 frame 2", frames[2], 24'h080200);
        check(nsamp == 0, "R6 no samples in self-test", nsamp, 0);
        check(test_pass && !test_fail, "R7 pass on 0xA5A", {test_pass, test_fail}, 2'b10);
        repeat (20) @(negedge clk);
        check(test_pass && !test_fail, "R7 flags held", {test_pass, test_fail}, 2'b10);

        // R7 self-test where the pattern never appears
        model_no_fix = 1; nfr = 0;
        kick(1'b1);
        check(!test_pass && !test_fail, "R7 flags cleared on start", {test_pass, test_fail}, 0);
        wait_done();
        check(!test_pass && test_fail, "R7 fail on wrong pattern", {test_pass, test_fail}, 2'b01);
        model_no_fix = 0;

        // R5 scan after self-test still aligned
        cur_vec = VEC[1]; nfr = 0; nsamp = 0;
        kick(1'b0);
        wait_done();
        check_scan(VEC[1]);
        check(!test_pass && test_fail, "R7 flags kept over scan", {test_pass, test_fail}, 2'b01);

        // Pin timing collected over the whole run
        check(bits_err == 0, "R1 rising edges per frame", bits_err, 0);
        check(idle_err == 0, "R1 sclk low while deselected", idle_err, 0);
        check(duty_err == 0, "R3 phase length", duty_err, 0);
        check(setup_err == 0, "R4 cs setup", setup_err, 0);
        check(gap_err == 0, "R4 cs gap", gap_err, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule